// File: doc/BRIEF.md
# Masked Control Register File

This block holds the privileged control registers of a processor core behind one indexed access port. A requester presents a 6-bit index with a read strobe, or with a write strobe and 64 bits of data. Each slot applies its own write rule: a bit mask, clear-on-any-write, refusal of writes, refusal of reads, or a control action that clears or keeps the data and emits a one-cycle invalidate pulse toward the translation caches. Accesses that are not allowed raise a one-cycle fault flag.

Read data comes from a register and is valid in the cycle after the read strobe. A cycle-count slot returns its stored upper half joined to a free-running lower count. A squash input cancels writes issued on a speculative path, so they change nothing, pulse nothing and never fault.

Slot numbers used below: 0-7 scratch, 8 handler base, 9 misc control, 10 exception address, 11 trap request, 12 trap enable, 13 current mode, 14 alternate mode, 15 interrupt control, 16 page-table base, 17 cache test, 18 cache mode, 19 instruction space id, 20 data space id, 21 exception summary, 22 exception mask, 23 interrupt id, 24 memory status, 25 table-entry temp, 26 cycle count, 27 invalidate all, 28 invalidate process, 29 invalidate address, 30 interrupt clear, 31 serial transmit. Indices 32-63 are unmapped.

Top module: `ctrl_reg_file`

## Requirements
- R1: After reset every slot reads zero except slot 9 (0x6), slot 8 (parameter HANDLER_BASE) and slot 7 (parameter CPU_ID); fault, the three invalidate pulses and the read data are low.
- R2: A read strobe returns the slot value on rd_data_o in the next cycle; in a cycle after no legal read rd_data_o is zero. Read and write strobes are never both high.
- R3: Writes keep only the masked bits: slot 15 0xffffff0300, slot 16 0xffffffffc0000000, slot 17 0x1ffb, slot 18 0x3f, slot 19 0x7f0, slot 20 0xfe00000000000000; slots 0-9 keep all 64 bits.
- R4: A write to slot 10 stores the data with bit 1 forced to zero; slots 11 and 12 keep bits 3:0; slots 13 and 14 keep bits 4:3 (mask 0x18).
- R5: Any write to slot 21 or 22 sets that slot to zero regardless of the data.
- R6: A write to slot 23, 24 or 25 raises fault_o in the next cycle and leaves the slot unchanged; reads of them succeed.
- R7: A read of slot 27, 28, 29, 30 or 31 raises fault_o in the next cycle with rd_data_o zero; writes to 30 and 31 store the full data without fault.
- R8: A write to slot 27 clears it and raises flush_all_o for exactly the next cycle; slot 28 likewise raises flush_proc_o.
- R9: A write to slot 29 stores the data, presents it on flush_va_o and raises flush_addr_o for exactly the next cycle.
- R10: A read of slot 26 returns the stored bits 63:32 joined to the low 32 bits of a counter that is zero in the cycle after reset release and adds one every cycle; writes store all 64 bits.
- R11: A write with squash_i high changes no slot, raises no fault and no pulse.
- R12: A read or unsquashed write to an index of 32 or above raises fault_o for one cycle and changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| squash_i | input | 1 | Cancels a write made on a speculative path |
| idx_i | input | 6 | Slot index |
| wdata_i | input | 64 | Write data |
| rd_data_o | output | 64 | Registered read data |
| fault_o | output | 1 | Illegal access, one cycle after the access |
| flush_all_o | output | 1 | Invalidate-all pulse |
| flush_proc_o | output | 1 | Invalidate-process pulse |
| flush_addr_o | output | 1 | Invalidate-address pulse |
| flush_va_o | output | 64 | Address for the invalidate-address pulse |

## Verification
The assertions take for granted that the requester never raises the read and write strobes together, and that the strobes, index and squash are clean after reset; the bench drives exactly one access or an idle cycle per clock on the falling edge, so the strobes are exclusive by construction. The pulse-origin and fault-origin properties also assume that a pulse or fault can only follow an access in the previous cycle, which holds because the stimulus places an idle cycle after each sequence. The bench models the slot contents from the listed masks and rules and predicts the cycle counter from its own count of cycles since reset.

// File: rtl/ctrlreg_pkg.sv
package ctrlreg_pkg;

    localparam int XLEN      = 64;
    localparam int NUM_SLOTS = 32;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [SLOT_W-1:0] {
        SL_SCR0    = 5'd0,  SL_SCR1    = 5'd1,  SL_SCR2   = 5'd2,  SL_SCR3    = 5'd3,
        SL_SCR4    = 5'd4,  SL_SCR5    = 5'd5,  SL_SCR6   = 5'd6,  SL_SCR7    = 5'd7,
        SL_HBASE   = 5'd8,  SL_MISC    = 5'd9,  SL_EXCADR = 5'd10, SL_TRAPREQ = 5'd11,
        SL_TRAPEN  = 5'd12, SL_CURMODE = 5'd13, SL_ALTMOD = 5'd14, SL_INTCTL  = 5'd15,
        SL_PTBASE  = 5'd16, SL_CTEST   = 5'd17, SL_CMODE  = 5'd18, SL_ISPACE  = 5'd19,
        SL_DSPACE  = 5'd20, SL_EXCSUM  = 5'd21, SL_EXCMSK = 5'd22, SL_INTID   = 5'd23,
        SL_MMSTAT  = 5'd24, SL_PTETMP  = 5'd25, SL_CYCLE  = 5'd26, SL_INVALL  = 5'd27,
        SL_INVPROC = 5'd28, SL_INVADDR = 5'd29, SL_HWCLR  = 5'd30, SL_SERTX   = 5'd31
    } slot_e;

    typedef enum logic [2:0] {
        K_PLAIN, K_CLEAR, K_RDONLY, K_WRONLY, K_INVALL, K_INVPROC, K_INVADDR, K_CYCLE
    } kind_e;

    typedef struct packed {
        kind_e kind;
        word_t mask;
    } rule_t;

    // pulse vector order: {all, process, address}
    typedef struct packed {
        logic       rd_go;
        logic       cyc_rd;
        logic       wr_go;
        logic       fault;
        logic [2:0] pulse;
        slot_e      slot;
        word_t      wval;
    } access_t;

    localparam word_t ONES = {XLEN{1'b1}};

    function automatic rule_t slot_rule(input slot_e s);
        rule_t r;
        r.kind = K_PLAIN;
        r.mask = ONES;
        case (s)
            SL_EXCADR:               r.mask = ~word_t'(64'h2);
            SL_TRAPREQ, SL_TRAPEN:   r.mask = word_t'(64'hf);
            SL_CURMODE, SL_ALTMOD:   r.mask = word_t'(64'h18);
            SL_INTCTL:               r.mask = word_t'(64'hff_ffff_0300);
            SL_PTBASE:               r.mask = word_t'(64'hffff_ffff_c000_0000);
            SL_CTEST:                r.mask = word_t'(64'h1ffb);
            SL_CMODE:                r.mask = word_t'(64'h3f);
            SL_ISPACE:               r.mask = word_t'(64'h7f0);
            SL_DSPACE:               r.mask = word_t'(64'hfe00_0000_0000_0000);
            SL_EXCSUM, SL_EXCMSK:    r.kind = K_CLEAR;
            SL_INTID, SL_MMSTAT,
            SL_PTETMP:               r.kind = K_RDONLY;
            SL_CYCLE:                r.kind = K_CYCLE;
            SL_INVALL:               r.kind = K_INVALL;
            SL_INVPROC:              r.kind = K_INVPROC;
            SL_INVADDR:              r.kind = K_INVADDR;
            SL_HWCLR, SL_SERTX:      r.kind = K_WRONLY;
            default:                 r.kind = K_PLAIN;
        endcase
        return r;
    endfunction

    function automatic logic kind_readable(input kind_e k);
        return (k == K_PLAIN) || (k == K_CLEAR) || (k == K_RDONLY) || (k == K_CYCLE);
    endfunction

    function automatic word_t reset_val(input slot_e s, input word_t hbase, input word_t cpu_id);
        case (s)
            SL_HBASE: return hbase;
            SL_MISC:  return word_t'(64'h6);
            SL_SCR7:  return cpu_id;
            default:  return '0;
        endcase
    endfunction

endpackage

// File: rtl/ctrlreg_decode.sv
module ctrlreg_decode
    import ctrlreg_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             rd_en_i,
    input  logic             wr_en_i,
    input  logic             squash_i,
    input  logic [IDX_W-1:0] idx_i,
    input  word_t            wdata_i,
    output access_t          acc_o
);

    logic  mapped;
    logic  wr_live;
    rule_t rule;
    slot_e slot;

    assign mapped  = ({1'b0, idx_i} < (IDX_W+1)'(NUM_SLOTS));
    assign wr_live = wr_en_i && !squash_i;
    assign slot    = slot_e'(idx_i[SLOT_W-1:0]);
    assign rule    = slot_rule(slot);

    always_comb begin
        acc_o        = '0;
        acc_o.slot   = slot;
        if (!mapped) begin
            acc_o.fault = rd_en_i || wr_live;
        end else begin
            if (rd_en_i) begin
                if (kind_readable(rule.kind)) begin
                    acc_o.rd_go  = 1'b1;
                    acc_o.cyc_rd = (rule.kind == K_CYCLE);
                end else begin
                    acc_o.fault  = 1'b1;
                end
            end
            if (wr_live) begin
                case (rule.kind)
                    K_RDONLY:  acc_o.fault = 1'b1;
                    K_CLEAR: begin
                        acc_o.wr_go = 1'b1;
                        acc_o.wval  = '0;
                    end
                    K_INVALL: begin
                        acc_o.wr_go = 1'b1;
                        acc_o.wval  = '0;
                        acc_o.pulse = 3'b100;
                    end
                    K_INVPROC: begin
                        acc_o.wr_go = 1'b1;
                        acc_o.wval  = '0;
                        acc_o.pulse = 3'b010;
                    end
                    K_INVADDR: begin
                        acc_o.wr_go = 1'b1;
                        acc_o.wval  = wdata_i;
                        acc_o.pulse = 3'b001;
                    end
                    default: begin
                        acc_o.wr_go = 1'b1;
                        acc_o.wval  = wdata_i & rule.mask;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/ctrlreg_bank.sv
module ctrlreg_bank
    import ctrlreg_pkg::*;
#(
    parameter word_t HANDLER_BASE = 64'h0,
    parameter word_t CPU_ID       = 64'h0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_go_i,
    input  slot_e slot_i,
    input  word_t wval_i,
    output word_t regs_o [NUM_SLOTS]
);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam slot_e ME = slot_e'(SLOT_W'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_o[g] <= reset_val(ME, HANDLER_BASE, CPU_ID);
            end else if (wr_go_i && (slot_i == ME)) begin
                regs_o[g] <= wval_i;
            end
        end
    end

    AST_EXCADR_BIT1_LOW: assert property (@(posedge clk) disable iff (rst)
        !regs_o[SL_EXCADR][1]); // R4

    AST_MODE_BITS_ONLY: assert property (@(posedge clk) disable iff (rst)
        (regs_o[SL_CURMODE] & ~word_t'(64'h18)) == '0); // R4

    AST_CLEAR_SLOTS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (regs_o[SL_EXCSUM] == '0) && (regs_o[SL_EXCMSK] == '0)); // R5

endmodule

// File: rtl/ctrlreg_tick.sv
module ctrlreg_tick #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] count_o
);

    always_ff @(posedge clk) begin
        if (rst) count_o <= '0;
        else     count_o <= count_o + 1'b1;
    end

    AST_TICK_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> count_o == $past(count_o) + 1'b1); // R10

endmodule

// File: rtl/ctrl_reg_file.sv
module ctrl_reg_file
    import ctrlreg_pkg::*;
#(
    parameter int    IDX_W        = 6,
    parameter int    CNT_W        = 32,
    parameter word_t HANDLER_BASE = 64'h0000_0000_0001_0000,
    parameter word_t CPU_ID       = 64'h0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en_i,
    input  logic             wr_en_i,
    input  logic             squash_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [63:0]      wdata_i,
    output logic [63:0]      rd_data_o,
    output logic             fault_o,
    output logic             flush_all_o,
    output logic             flush_proc_o,
    output logic             flush_addr_o,
    output logic [63:0]      flush_va_o
);

    localparam logic [IDX_W-1:0] IDX_INVALL = IDX_W'(SL_INVALL);
    localparam logic [IDX_W:0]   IDX_LIMIT  = (IDX_W+1)'(NUM_SLOTS);

    access_t          acc;
    word_t            regs [NUM_SLOTS];
    logic [CNT_W-1:0] tick;
    word_t            rd_word;

    ctrlreg_decode #(.IDX_W(IDX_W)) u_dec (
        .rd_en_i  (rd_en_i),
        .wr_en_i  (wr_en_i),
        .squash_i (squash_i),
        .idx_i    (idx_i),
        .wdata_i  (wdata_i),
        .acc_o    (acc)
    );

    ctrlreg_bank #(.HANDLER_BASE(HANDLER_BASE), .CPU_ID(CPU_ID)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_go_i (acc.wr_go),
        .slot_i  (acc.slot),
        .wval_i  (acc.wval),
        .regs_o  (regs)
    );

    ctrlreg_tick #(.CNT_W(CNT_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .count_o (tick)
    );

    always_comb begin
        if (acc.cyc_rd) rd_word = {regs[SL_CYCLE][XLEN-1:CNT_W], tick};
        else            rd_word = regs[acc.slot];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_o    <= '0;
            fault_o      <= 1'b0;
            flush_all_o  <= 1'b0;
            flush_proc_o <= 1'b0;
            flush_addr_o <= 1'b0;
        end else begin
            rd_data_o    <= acc.rd_go ? rd_word : '0;
            fault_o      <= acc.fault;
            flush_all_o  <= acc.pulse[2];
            flush_proc_o <= acc.pulse[1];
            flush_addr_o <= acc.pulse[0];
        end
    end

    assign flush_va_o = regs[SL_INVADDR];

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(rd_en_i && wr_en_i)); // R2

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |=> rd_data_o == '0); // R2

    AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flush_all_o, flush_proc_o, flush_addr_o})); // R8

    AST_FLUSH_ALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        flush_all_o |-> $past(wr_en_i && !squash_i && idx_i == IDX_INVALL)); // R8

    AST_SQUASH_QUIET: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && squash_i) |=> !fault_o && !flush_all_o && !flush_proc_o && !flush_addr_o); // R11

    AST_UNMAPPED_FAULT: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && ({1'b0, idx_i} >= IDX_LIMIT)) |=> fault_o); // R12

    AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> $past(rd_en_i || (wr_en_i && !squash_i))); // R12

endmodule

// File: tb/sim_ctrl_reg_file.sv
module sim_ctrl_reg_file;

    localparam logic [63:0] HBASE = 64'h0000_0000_0004_0000;
    localparam logic [63:0] CPUID = 64'h0000_0000_0000_0003;

    typedef struct {
        logic [63:0] data;
        logic        fault;
        logic [2:0]  pulse;
        logic [63:0] va;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0, wr_en = 1'b0, squash = 1'b0;
    logic [5:0]  idx = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rd_data, flush_va;
    logic        fault, f_all, f_proc, f_addr;

    logic [63:0] model [32];
    logic [31:0] tb_cnt;
    item_t       exp_q [$];
    int          n_vec = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    ctrl_reg_file #(.HANDLER_BASE(HBASE), .CPU_ID(CPUID)) u0 (
        .clk(clk), .rst(rst), .rd_en_i(rd_en), .wr_en_i(wr_en), .squash_i(squash),
        .idx_i(idx), .wdata_i(wdata), .rd_data_o(rd_data), .fault_o(fault),
        .flush_all_o(f_all), .flush_proc_o(f_proc), .flush_addr_o(f_addr),
        .flush_va_o(flush_va)
    );

    always_ff @(posedge clk) begin
        if (rst) tb_cnt <= '0;
        else     tb_cnt <= tb_cnt + 1'b1;
    end

    function automatic logic [63:0] mask_of(int i);
        case (i)
            10:      return ~64'h2;
            11, 12:  return 64'hf;
            13, 14:  return 64'h18;
            15:      return 64'hff_ffff_0300;
            16:      return 64'hffff_ffff_c000_0000;
            17:      return 64'h1ffb;
            18:      return 64'h3f;
            19:      return 64'h7f0;
            20:      return 64'hfe00_0000_0000_0000;
            default: return '1;
        endcase
    endfunction

    task automatic do_idle(string req);
        item_t it;
        @(negedge clk);
        rd_en = 0; wr_en = 0; squash = 0; idx = '0; wdata = '0;
        it.data = '0; it.fault = 0; it.pulse = '0; it.va = model[29]; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic do_wr(int i, logic [63:0] v, bit sq, string req);
        item_t it;
        @(negedge clk);
        rd_en = 0; wr_en = 1; squash = sq; idx = 6'(i); wdata = v;
        it.data = '0; it.fault = 0; it.pulse = '0; it.req = req;
        if (!sq) begin
            if (i >= 32 || i == 23 || i == 24 || i == 25) it.fault = 1;
            else if (i == 21 || i == 22) model[i] = '0;
            else if (i == 27) begin model[i] = '0; it.pulse = 3'b100; end
            else if (i == 28) begin model[i] = '0; it.pulse = 3'b010; end
            else if (i == 29) begin model[i] = v;  it.pulse = 3'b001; end
            else model[i] = v & mask_of(i);
        end
        it.va = model[29];
        exp_q.push_back(it);
    endtask

    task automatic do_rd(int i, string req);
        item_t it;
        @(negedge clk);
        rd_en = 1; wr_en = 0; squash = 0; idx = 6'(i); wdata = '0;
        it.fault = 0; it.pulse = '0; it.va = model[29]; it.req = req;
        if (i >= 27) begin it.fault = 1; it.data = '0; end
        else if (i == 26) it.data = {model[26][63:32], tb_cnt};
        else it.data = model[i];
        exp_q.push_back(it);
    endtask

    // monitor: compares one expected item per cycle, away from the edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() != 0) begin
            item_t it;
            it = exp_q.pop_front();
            n_vec++;
            if (rd_data !== it.data) begin
                n_bad++;
                $display("FAIL %s rd_data act=%h exp=%h", it.req, rd_data, it.data);
            end
            if (fault !== it.fault) begin
                n_bad++;
                $display("FAIL %s fault act=%b exp=%b", it.req, fault, it.fault);
            end
            if ({f_all, f_proc, f_addr} !== it.pulse) begin
                n_bad++;
                $display("FAIL %s pulses act=%b exp=%b", it.req, {f_all, f_proc, f_addr}, it.pulse);
            end
            if (flush_va !== it.va) begin
                n_bad++;
                $display("FAIL %s flush_va act=%h exp=%h", it.req, flush_va, it.va);
            end
        end
    end

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        model[7] = CPUID; model[8] = HBASE; model[9] = 64'h6;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        do_idle("R1");
        do_rd(7, "R1"); do_rd(8, "R1"); do_rd(9, "R1"); do_rd(15, "R1"); do_rd(0, "R1");

        // R2 plain scratch, back-to-back read then idle
        do_wr(0, 64'h0123_4567_89ab_cdef, 0, "R2");
        do_rd(0, "R2"); do_idle("R2");
        do_wr(9, 64'hffff_0000_ffff_0000, 0, "R3"); do_rd(9, "R3");

        // R3 masks
        for (int i = 15; i <= 20; i++) begin
            do_wr(i, '1, 0, "R3"); do_rd(i, "R3");
        end
        do_wr(15, 64'ha5a5_a5a5_a5a5_a5a5, 0, "R3"); do_rd(15, "R3");

        // R4 special masks
        do_wr(10, '1, 0, "R4"); do_rd(10, "R4");
        do_wr(10, 64'h1234_5676, 0, "R4"); do_rd(10, "R4");
        for (int i = 11; i <= 14; i++) begin
            do_wr(i, '1, 0, "R4"); do_rd(i, "R4");
        end

        // R5 clear on write
        do_wr(21, '1, 0, "R5"); do_rd(21, "R5");
        do_wr(22, 64'h55, 0, "R5"); do_rd(22, "R5");

        // R6 read-only
        do_wr(23, '1, 0, "R6"); do_rd(23, "R6");
        do_wr(25, 64'h77, 0, "R6"); do_rd(25, "R6");

        // R7 write-only
        do_rd(30, "R7"); do_rd(31, "R7"); do_rd(27, "R7"); do_rd(29, "R7");
        do_wr(30, 64'h99, 0, "R7"); do_idle("R7");

        // R8 invalidate all / process
        do_wr(27, '1, 0, "R8"); do_idle("R8");
        do_wr(28, 64'h5, 0, "R8"); do_idle("R8");

        // R9 invalidate address
        do_wr(29, 64'hdead_beef_0000_1000, 0, "R9"); do_idle("R9");

        // R10 cycle count
        do_wr(26, 64'h1234_5678_9abc_def0, 0, "R10"); do_rd(26, "R10");
        do_idle("R10"); do_idle("R10"); do_rd(26, "R10");

        // R11 squash
        do_wr(0, 64'hffff_ffff_ffff_ffff, 1, "R11"); do_rd(0, "R11");
        do_wr(27, '1, 1, "R11"); do_wr(23, '1, 1, "R11");
        do_wr(29, 64'h1, 1, "R11"); do_idle("R11");

        // R12 unmapped
        do_rd(40, "R12"); do_wr(63, '1, 0, "R12"); do_idle("R12");
        do_rd(0, "R12"); do_rd(31 + 1, "R12"); do_idle("R12");

        wait (exp_q.size() == 0);
        @(posedge clk); #3;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule